// File: doc/BRIEF.md
# Control Endpoint IN Buffer Controller

This block handles the device side of the IN data stage on a default control endpoint. Firmware pushes the bytes of one packet into a small transmit buffer through a valid/ready byte stream. It then arms that packet with a one-cycle strobe. A packet is offered to the host only once it is armed. The block answers each host IN token with the armed packet, or with a NACK when nothing is ready. When the host acknowledges a sent packet, a sticky completion flag is set and an interrupt can be raised. Firmware clears the flag and loads the next packet.

IN readiness is also gated on firmware confirming that it has read the setup command. Until then every IN token gets a NACK. The block tracks the control-transfer stage. A packet shorter than the maximum packet size ends the data stage, and so does an armed zero-length packet, which is used when the total length is an exact multiple of that size. An OUT token moves the endpoint into the status stage. A SETUP token returns everything to idle. Serial signalling, CRC, bit stuffing, SETUP decoding and the OUT data path live elsewhere.

Both streams follow the usual valid/ready rule: a beat transfers on a clock edge where valid and ready are both high. On the write stream, `wr_ready` drops while a packet is armed, while `arm_req` is high, and while the buffer is full. On the transmit stream, the block holds `tx_valid`, `tx_data`, `tx_last` and `tx_zlp` steady until `tx_ready` accepts the beat.

Top module: `ep0_in_ctrl`

## Requirements
- R1: After reset, wr_ready is 1, and armed, done_flag, irq, end_seen, tx_valid and nak_pulse are 0, and stage is 0 (idle).
- R2: Bytes are accepted on the write stream, in order, up to MAX_PKT bytes. wr_ready is 0 when the buffer holds MAX_PKT bytes, while armed is 1, and while arm_req is high, and no byte is stored then.
- R3: An arm_req strobe while not armed sets armed on the next cycle and fixes the packet length at the number of bytes then buffered.
- R4: An IN token (tok_kind 2'b01) is answered by a one-cycle nak_pulse in the cycle after the token when no packet is armed, or when stage is not 1 (data), for example before setup_rd_ack has been given.
- R5: An IN token while armed and in stage 1 starts the transmit stream in the next cycle. The buffered bytes go out in write order, tx_last is 1 only on the final byte, and each beat is held unchanged while tx_ready is 0.
- R6: A packet armed with zero bytes goes out as a single beat with tx_zlp = 1 and tx_last = 1.
- R7: hs_ack after the final beat clears armed, sets done_flag and empties the buffer (wr_ready back to 1) on the next cycle. irq equals done_flag AND irq_en.
- R8: hs_lost after the final beat keeps the packet armed, and the next IN token resends the same bytes.
- R9: clr_done = 1 clears done_flag on the next cycle, unless hs_ack sets it in the same cycle, in which case the flag stays 1.
- R10: end_seen becomes 1 when an acknowledged packet is shorter than MAX_PKT, a zero-length packet included. An acknowledged full-size packet leaves end_seen unchanged.
- R11: stage encodes 0 idle, 1 data, 2 status. setup_rd_ack moves idle to data. An OUT token (tok_kind 2'b10) moves data to status and is ignored in idle. An IN token in status gets a NACK.
- R12: A SETUP token (tok_kind 2'b11) in any state sets, on the next cycle: stage 0, armed 0, an empty buffer, end_seen 0 and tx_valid 0. done_flag is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Firmware byte valid |
| wr_ready | output | 1 | Buffer can take a byte |
| wr_data | input | DATA_W | Firmware byte |
| arm_req | input | 1 | Packet-enable strobe |
| setup_rd_ack | input | 1 | Firmware has read the setup command |
| clr_done | input | 1 | Write-1 clear of done_flag |
| irq_en | input | 1 | Interrupt enable |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | 01 IN, 10 OUT, 11 SETUP |
| hs_ack | input | 1 | Host acknowledged the sent packet |
| hs_lost | input | 1 | Host handshake missing or timed out |
| nak_pulse | output | 1 | Send NACK for the last IN token |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | DATA_W | Transmit byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat stands for a zero-length packet |
| armed | output | 1 | A packet is armed |
| done_flag | output | 1 | Sticky transmit-complete flag |
| irq | output | 1 | Interrupt request |
| stage | output | 2 | Control transfer stage |
| end_seen | output | 1 | Data stage ended by short or zero-length packet |

## Verification
The bench builds the block with MAX_PKT = 4 and DATA_W = 8. A full buffer, a full-size packet whose acknowledgement leaves the stage open, and the zero-length packet that closes such a transfer each then take only a few cycles to reach. With four bytes, the rejection of a fifth byte on a full buffer and the exact-multiple case are both exercised, next to two-byte short packets and a stream stalled by tx_ready.

// File: rtl/ep0_in_pkg.sv
package ep0_in_pkg;
  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_IN    = 2'b01,
    TK_OUT   = 2'b10,
    TK_SETUP = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_STATUS = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    EG_IDLE = 2'd0,
    EG_SEND = 2'd1,
    EG_WAIT = 2'd2
  } eng_e;
endpackage

// File: rtl/ep0_in_fifo.sv
module ep0_in_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [DATA_W-1:0]         push_data,
  input  logic                      flush,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic [DATA_W-1:0]         rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                      full
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];

  assign full    = (fill == CNT_W'(DEPTH));
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (flush) begin
      fill <= '0;
    end else if (push && !full) begin
      fill <= fill + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) begin
      mem[fill[IDX_W-1:0]] <= push_data;
    end
  end

  // R2: the count never exceeds the buffer size
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  // R2: no push is offered while the buffer is already full
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/ep0_in_engine.sv
module ep0_in_engine
  import ep0_in_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tok_in,
  input  logic                         setup_tok,
  input  logic                         in_allowed,
  input  logic                         arm_req,
  input  logic [$clog2(MAX_PKT+1)-1:0] fill,
  input  logic [DATA_W-1:0]            rd_data,
  input  logic                         tx_ready,
  input  logic                         hs_ack,
  input  logic                         hs_lost,
  output logic                         armed,
  output logic                         nak_pulse,
  output logic                         tx_valid,
  output logic [DATA_W-1:0]            tx_data,
  output logic                         tx_last,
  output logic                         tx_zlp,
  output logic [$clog2(MAX_PKT)-1:0]   rd_idx,
  output logic                         ack_evt,
  output logic                         short_evt
);
  localparam int IDX_W = $clog2(MAX_PKT);
  localparam int CNT_W = $clog2(MAX_PKT + 1);

  eng_e             state;
  logic [CNT_W-1:0] pkt_len;
  logic             nak_q;

  assign armed     = (state != EG_IDLE) || armed_q;
  assign nak_pulse = nak_q;
  assign tx_valid  = (state == EG_SEND);
  assign tx_zlp    = tx_valid && (pkt_len == '0);
  assign tx_data   = rd_data;
  assign tx_last   = tx_valid &&
                     ((pkt_len == '0) || (CNT_W'(rd_idx) == pkt_len - CNT_W'(1)));
  assign ack_evt   = (state == EG_WAIT) && hs_ack && !setup_tok;
  assign short_evt = ack_evt && (pkt_len < CNT_W'(MAX_PKT));

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= EG_IDLE;
      armed_q <= 1'b0;
      pkt_len <= '0;
      nak_q   <= 1'b0;
      rd_idx  <= '0;
    end else if (setup_tok) begin
      state   <= EG_IDLE;
      armed_q <= 1'b0;
      nak_q   <= 1'b0;
      rd_idx  <= '0;
    end else begin
      nak_q <= 1'b0;
      if (arm_req && !armed_q) begin
        armed_q <= 1'b1;
        pkt_len <= fill;
      end
      case (state)
        EG_IDLE: begin
          if (tok_in) begin
            if (armed_q && in_allowed) begin
              state  <= EG_SEND;
              rd_idx <= '0;
            end else begin
              nak_q <= 1'b1;
            end
          end
        end
        EG_SEND: begin
          if (tx_ready) begin
            if (tx_last) state <= EG_WAIT;
            else         rd_idx <= rd_idx + IDX_W'(1);
          end
        end
        EG_WAIT: begin
          if (hs_ack) begin
            state   <= EG_IDLE;
            armed_q <= 1'b0;
            rd_idx  <= '0;
          end else if (hs_lost) begin
            state  <= EG_IDLE;
            rd_idx <= '0;
          end
        end
        default: state <= EG_IDLE;
      endcase
    end
  end

  // R4: a NACK and a data beat never go out together
  a_r4_nak_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nak_pulse && tx_valid));

  // R5: a stalled beat stays unchanged
  a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n || setup_tok)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R3: arming fixes the length at the buffered count
  a_r3_arm_len: assert property (@(posedge clk) disable iff (!rst_n || setup_tok)
    (arm_req && !armed_q) |=> (armed_q && pkt_len == $past(fill)));

  // R7: an acknowledged packet is disarmed
  a_r7_ack_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !armed);

  // R8: a lost handshake keeps the packet armed
  a_r8_lost_keeps: assert property (@(posedge clk) disable iff (!rst_n || setup_tok)
    ((state == EG_WAIT) && hs_lost && !hs_ack) |=> armed_q);
endmodule

// File: rtl/ep0_in_stage.sv
module ep0_in_stage
  import ep0_in_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_tok,
  input  logic       out_tok,
  input  logic       setup_rd_ack,
  input  logic       ack_evt,
  input  logic       short_evt,
  input  logic       clr_done,
  input  logic       irq_en,
  output stage_e     stage,
  output logic       end_seen,
  output logic       done_flag,
  output logic       irq
);
  assign irq = done_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= ST_IDLE;
      end_seen <= 1'b0;
    end else if (setup_tok) begin
      stage    <= ST_IDLE;
      end_seen <= 1'b0;
    end else begin
      if (stage == ST_IDLE && setup_rd_ack) stage <= ST_DATA;
      else if (stage == ST_DATA && out_tok) stage <= ST_STATUS;
      if (short_evt) end_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (ack_evt)  done_flag <= 1'b1;
    else if (clr_done) done_flag <= 1'b0;
  end

  // R7: an acknowledged packet raises the flag
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> done_flag);

  // R11: the status stage is left only through a SETUP token
  a_r11_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_STATUS && !setup_tok) |=> (stage == ST_STATUS));

  // R12: a SETUP token returns the stage to idle
  a_r12_setup_idle: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> (stage == ST_IDLE && !end_seen));
endmodule

// File: rtl/ep0_in_ctrl.sv
module ep0_in_ctrl
  import ep0_in_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              arm_req,
  input  logic              setup_rd_ack,
  input  logic              clr_done,
  input  logic              irq_en,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              hs_ack,
  input  logic              hs_lost,
  output logic              nak_pulse,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_zlp,
  output logic              armed,
  output logic              done_flag,
  output logic              irq,
  output logic [1:0]        stage,
  output logic              end_seen
);
  localparam int IDX_W = $clog2(MAX_PKT);
  localparam int CNT_W = $clog2(MAX_PKT + 1);

  logic             tok_in, tok_out, setup_tok;
  logic             push, flush, full;
  logic [CNT_W-1:0] fill;
  logic [IDX_W-1:0] rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic             ack_evt, short_evt;
  stage_e           stage_q;

  assign tok_in    = tok_valid && (tok_kind == TK_IN);
  assign tok_out   = tok_valid && (tok_kind == TK_OUT);
  assign setup_tok = tok_valid && (tok_kind == TK_SETUP);

  assign wr_ready = !armed && !arm_req && !full;
  assign push     = wr_valid && wr_ready;
  assign flush    = ack_evt || setup_tok;
  assign stage    = stage_q;

  ep0_in_fifo #(.DATA_W(DATA_W), .DEPTH(MAX_PKT)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
    .flush(flush), .rd_idx(rd_idx), .rd_data(rd_data),
    .fill(fill), .full(full)
  );

  ep0_in_engine #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) eng_i (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .setup_tok(setup_tok),
    .in_allowed(stage_q == ST_DATA), .arm_req(arm_req), .fill(fill),
    .rd_data(rd_data), .tx_ready(tx_ready), .hs_ack(hs_ack), .hs_lost(hs_lost),
    .armed(armed), .nak_pulse(nak_pulse), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp), .rd_idx(rd_idx),
    .ack_evt(ack_evt), .short_evt(short_evt)
  );

  ep0_in_stage stage_i (
    .clk(clk), .rst_n(rst_n), .setup_tok(setup_tok), .out_tok(tok_out),
    .setup_rd_ack(setup_rd_ack), .ack_evt(ack_evt), .short_evt(short_evt),
    .clr_done(clr_done), .irq_en(irq_en), .stage(stage_q),
    .end_seen(end_seen), .done_flag(done_flag), .irq(irq)
  );

  // R2: the buffer takes no byte while a packet is armed
  a_r2_no_push_armed: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !push);
endmodule

// File: tb/ep0_in_ctrl_tb_top.sv
`timescale 1ns/100ps
module ep0_in_ctrl_tb_top;
  localparam int DW  = 8;
  localparam int MPS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, arm_req = 0, setup_rd_ack = 0, clr_done = 0, irq_en = 0;
  logic tok_valid = 0, hs_ack = 0, hs_lost = 0, tx_ready = 0;
  logic [1:0] tok_kind = 2'b00;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, nak_pulse, tx_valid, tx_last, tx_zlp, armed, done_flag, irq, end_seen;
  logic [DW-1:0] tx_data;
  logic [1:0] stage;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ep0_in_ctrl #(.DATA_W(DW), .MAX_PKT(MPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .arm_req(arm_req), .setup_rd_ack(setup_rd_ack),
    .clr_done(clr_done), .irq_en(irq_en), .tok_valid(tok_valid),
    .tok_kind(tok_kind), .hs_ack(hs_ack), .hs_lost(hs_lost),
    .nak_pulse(nak_pulse), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp), .armed(armed),
    .done_flag(done_flag), .irq(irq), .stage(stage), .end_seen(end_seen)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic arm();
    arm_req = 1'b1;
    @(negedge clk);
    arm_req = 1'b0;
  endtask

  task automatic token(input logic [1:0] k);
    tok_valid = 1'b1; tok_kind = k;
    @(negedge clk);
    tok_valid = 1'b0; tok_kind = 2'b00;
  endtask

  task automatic pulse_setup_ack();
    setup_rd_ack = 1'b1;
    @(negedge clk);
    setup_rd_ack = 1'b0;
  endtask

  task automatic handshake(input logic ok);
    if (ok) hs_ack = 1'b1; else hs_lost = 1'b1;
    @(negedge clk);
    hs_ack = 1'b0; hs_lost = 1'b0;
  endtask

  // receive n bytes starting at base (byte i = base + i) with tx_ready high
  task automatic receive(input string req, input int n, input logic [DW-1:0] base);
    tx_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk(req, "tx_valid", tx_valid, 1'b1);
      chk(req, "tx_data", tx_data, base + DW'(i));
      chk(req, "tx_last", tx_last, (i == n - 1));
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk(req, "tx_valid after packet", tx_valid, 1'b0);
  endtask

  task automatic load(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) push_byte(base + DW'(i));
  endtask

  task automatic t_reset();
    chk("R1", "wr_ready", wr_ready, 1'b1);
    chk("R1", "armed", armed, 1'b0);
    chk("R1", "done_flag", done_flag, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "end_seen", end_seen, 1'b0);
    chk("R1", "tx_valid", tx_valid, 1'b0);
    chk("R1", "nak_pulse", nak_pulse, 1'b0);
    chk("R1", "stage", stage, 2'd0);
  endtask

  task automatic t_nak_empty();
    token(2'b01);
    chk("R4", "nak with nothing armed", nak_pulse, 1'b1);
    chk("R4", "no beat", tx_valid, 1'b0);
    @(negedge clk);
    chk("R4", "nak lasts one cycle", nak_pulse, 1'b0);
    token(2'b10);
    chk("R11", "OUT ignored in idle", stage, 2'd0);
  endtask

  task automatic t_fill_and_gate();
    load(MPS, 8'h10);
    chk("R2", "wr_ready low when full", wr_ready, 1'b0);
    push_byte(8'hEE);
    arm_req = 1'b1;
    #1 chk("R2", "wr_ready low during arm_req", wr_ready, 1'b0);
    @(negedge clk);
    arm_req = 1'b0;
    chk("R3", "armed after strobe", armed, 1'b1);
    chk("R2", "wr_ready low while armed", wr_ready, 1'b0);
    token(2'b01);
    chk("R4", "nak before setup_rd_ack", nak_pulse, 1'b1);
    pulse_setup_ack();
    chk("R11", "stage data after setup_rd_ack", stage, 2'd1);
  endtask

  task automatic t_full_send_backpressure();
    token(2'b01);
    chk("R5", "first beat valid", tx_valid, 1'b1);
    chk("R5", "first byte", tx_data, 8'h10);
    @(negedge clk);
    chk("R5", "stalled beat held", tx_data, 8'h10);
    chk("R5", "stalled valid held", tx_valid, 1'b1);
    receive("R5", MPS, 8'h10);
    handshake(1'b0);
    chk("R8", "armed after lost handshake", armed, 1'b1);
    chk("R8", "no flag after lost handshake", done_flag, 1'b0);
    token(2'b01);
    receive("R8", MPS, 8'h10);
    irq_en = 1'b1;
    handshake(1'b1);
    chk("R7", "disarmed", armed, 1'b0);
    chk("R7", "done_flag set", done_flag, 1'b1);
    chk("R7", "irq with enable", irq, 1'b1);
    chk("R7", "buffer emptied", wr_ready, 1'b1);
    chk("R10", "full-size packet leaves stage open", end_seen, 1'b0);
    irq_en = 1'b0;
    #1 chk("R7", "irq masked", irq, 1'b0);
  endtask

  task automatic t_clear_and_short();
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk("R9", "flag cleared", done_flag, 1'b0);
    load(2, 8'h40);
    arm();
    token(2'b01);
    receive("R5", 2, 8'h40);
    clr_done = 1'b1;
    handshake(1'b1);
    clr_done = 1'b0;
    chk("R9", "ack beats clear in same cycle", done_flag, 1'b1);
    chk("R10", "short packet ends stage", end_seen, 1'b1);
    token(2'b01);
    chk("R4", "nak after packet taken", nak_pulse, 1'b1);
    token(2'b10);
    chk("R11", "OUT moves to status", stage, 2'd2);
    load(1, 8'h55);
    arm();
    token(2'b01);
    chk("R11", "IN in status gets nak", nak_pulse, 1'b1);
    chk("R11", "no beat in status", tx_valid, 1'b0);
  endtask

  task automatic t_setup_and_zlp();
    token(2'b11);
    chk("R12", "stage idle", stage, 2'd0);
    chk("R12", "disarmed", armed, 1'b0);
    chk("R12", "end_seen cleared", end_seen, 1'b0);
    chk("R12", "buffer emptied", wr_ready, 1'b1);
    chk("R12", "flag kept", done_flag, 1'b1);
    pulse_setup_ack();
    load(MPS, 8'h20);
    arm();
    token(2'b01);
    receive("R5", MPS, 8'h20);
    handshake(1'b1);
    chk("R10", "multiple of size keeps stage open", end_seen, 1'b0);
    arm();
    token(2'b01);
    chk("R6", "zlp beat valid", tx_valid, 1'b1);
    chk("R6", "tx_zlp", tx_zlp, 1'b1);
    chk("R6", "tx_last", tx_last, 1'b1);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6", "zlp single beat", tx_valid, 1'b0);
    handshake(1'b1);
    chk("R10", "zlp ends stage", end_seen, 1'b1);
  endtask

  task automatic t_setup_abort();
    token(2'b11);
    pulse_setup_ack();
    load(3, 8'h70);
    arm();
    token(2'b01);
    chk("R5", "beat before abort", tx_valid, 1'b1);
    token(2'b11);
    chk("R12", "stream aborted", tx_valid, 1'b0);
    chk("R12", "disarmed on abort", armed, 1'b0);
    chk("R12", "stage idle on abort", stage, 2'd0);
    chk("R12", "buffer empty on abort", wr_ready, 1'b1);
    pulse_setup_ack();
    load(1, 8'h90);
    arm();
    token(2'b01);
    receive("R12", 1, 8'h90);
    handshake(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nak_empty();
    t_fill_and_gate();
    t_full_send_backpressure();
    t_clear_and_short();
    t_setup_and_zlp();
    t_setup_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule